// File: doc/BRIEF.md
# Serial core run/pause/reset state controller

This block is the register-side control of a serial bus core. Software moves the core between three operating modes through a mode register: reset, run and pause. Each accepted mode change restarts a settling window. During that window a settled flag in the same register reads low, and new mode writes are not taken. The bus engine is enabled only while the mode is run and the window has closed. Software can therefore fill the transmit FIFO while the core is paused and then let the engine go.

A second register applies a soft reset. It forces the reset mode, clears every pending flag and pulses a flush line to the FIFOs. A flag register shows live FIFO levels and keeps sticky service and done flags. An error register and an error enable register sit beside it. Sticky flags are cleared by writing 1 at their own bit. One interrupt line is the OR of the pending service and done flags and the enabled errors.

Top module: `rpr_ctl`

## Requirements
- R1: The mode register (address 0) reads the mode code in bits [1:0], the settled flag in bit 2 and the live master-ready input in bit 4. After reset it reads code 0 with bit 2 set.
- R2: A state write that is accepted loads the new code and clears bit 2 from the next cycle.
- R3: After an accepted write or soft reset, bit 2 stays low for exactly SETTLE clock cycles (default 6) and then returns high.
- R4: A write of code 2, or any mode write while bit 2 is low, is ignored: code and bit 2 keep their values.
- R5: Writing 1 to bit 0 of the soft-reset register (address 1) does the following. It forces code 0 and restarts the settling window. It clears all service, done and error flags. It drives fifo_flush high for the one following cycle and leaves irq low. The error enable register keeps its value.
- R6: engine_run is high only when the code is run (1) and bit 2 is set. Pause (3) and reset (0) hold it low.
- R7: The flag register (address 2) shows the live out_not_empty, in_not_empty and out_full inputs at bits 4, 5 and 6.
- R8: Flag register bits 8, 9, 10 and 11 are sticky (out service, in service, out done, in done). Each is cleared by writing 1 at its own position. Zero bits and bits outside 8..11 have no effect.
- R9: When a set event and a write-1 clear hit the same sticky bit in the same cycle, the set wins.
- R10: The error register (address 3) holds ERR_W sticky bits, each cleared by writing 1. The enable register (address 4) resets to 0. irq is the OR of the sticky service and done flags and the error bits whose enable bit is set.
- R11: An accepted write of code 0 to the mode register clears all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mst_ready | input | 1 | Master generator ready, shown at mode bit 4 |
| out_not_empty | input | 1 | Transmit FIFO holds data |
| in_not_empty | input | 1 | Receive FIFO holds data |
| out_full | input | 1 | Transmit FIFO full |
| out_svc_req | input | 1 | Transmit service event pulse |
| in_svc_req | input | 1 | Receive service event pulse |
| out_done_evt | input | 1 | Transmit count reached pulse |
| in_done_evt | input | 1 | Receive count reached pulse |
| err_evt | input | ERR_W | Error event pulses |
| engine_run | output | 1 | Bus engine enable |
| core_state | output | 2 | Current mode code |
| fifo_flush | output | 1 | One-cycle FIFO clear after soft reset |
| irq | output | 1 | Interrupt request |

## Verification
The mode register is tried with legal codes written after the window has closed, the illegal code, and a write that lands inside the window. This separates the acceptance gate from the code decode. The window is sampled one cycle before and at its end, which pins its length exactly. The sticky flags are driven by lone events, by a write of 1 to other bits, and by a set that collides with a clear. Errors are raised both masked and unmasked, then cleared by write-1, by a reset-mode write and by soft reset, so each clearing path is seen on its own.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    typedef enum logic [1:0] {
        MODE_RESET = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_PAUSE = 2'd3
    } mode_e;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SWRST = 3'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd2;
    localparam logic [ADDR_W-1:0] A_ERR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_ERREN = 3'd4;

    localparam int SVC_W   = 4;
    localparam int SVC_LSB = 8;
endpackage

// File: rtl/rpr_mode_ctl.sv
module rpr_mode_ctl
    import rpr_pkg::*;
#(
    parameter int SETTLE = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_mode,
    input  logic [1:0] wr_code,
    input  logic       force_reset,
    output logic [1:0] mode_o,
    output logic       settled_o,
    output logic       to_reset_o
);
    localparam int CW = $clog2(SETTLE + 1);

    typedef struct packed {
        mode_e         mode;
        logic [CW-1:0] cnt;
    } mode_st_t;

    mode_st_t st_d, st_q;
    logic     accept;

    always_comb begin
        st_d   = st_q;
        accept = wr_mode && (wr_code != 2'd2) && (st_q.cnt == '0);
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - CW'(1);
        if (force_reset) begin
            st_d.mode = MODE_RESET;
            st_d.cnt  = CW'(SETTLE);
        end else if (accept) begin
            st_d.mode = mode_e'(wr_code);
            st_d.cnt  = CW'(SETTLE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RESET;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o     = st_q.mode;
    assign settled_o  = (st_q.cnt == '0);
    assign to_reset_o = accept && (wr_code == 2'd0) && !force_reset;

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_mode && wr_code != 2'd2 && settled_o) || force_reset) |=> !settled_o);
    // R4
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && wr_code == 2'd2 && !force_reset) |=> $stable(mode_o));
    // R4
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !settled_o && !force_reset) |=> $stable(mode_o));
    // R1
    legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd2);
endmodule

// File: rtl/rpr_flag_bank.sv
module rpr_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         flush_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
        if (flush_i) flag_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i && !flush_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i && !flush_i) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
    // R5
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (q_o == '0));
endmodule

// File: rtl/rpr_ctl.sv
module rpr_ctl
    import rpr_pkg::*;
#(
    parameter int SETTLE = 6,
    parameter int ERR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              mst_ready,
    input  logic              out_not_empty,
    input  logic              in_not_empty,
    input  logic              out_full,
    input  logic              out_svc_req,
    input  logic              in_svc_req,
    input  logic              out_done_evt,
    input  logic              in_done_evt,
    input  logic [ERR_W-1:0]  err_evt,
    output logic              engine_run,
    output logic [1:0]        core_state,
    output logic              fifo_flush,
    output logic              irq
);
    typedef struct packed {
        logic             flush;
        logic [ERR_W-1:0] err_en;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             wr_mode, sw_rst, to_reset, settled;
    logic [1:0]       mode;
    logic [SVC_W-1:0] svc_q, svc_clr;
    logic [ERR_W-1:0] err_q, err_clr;
    logic             unused_wdata;

    assign wr_mode = reg_we && (reg_addr == A_MODE);
    assign sw_rst  = reg_we && (reg_addr == A_SWRST) && reg_wdata[0];
    assign svc_clr = (reg_we && reg_addr == A_FLAGS) ? reg_wdata[SVC_LSB +: SVC_W] : '0;
    assign err_clr = (reg_we && reg_addr == A_ERR) ? reg_wdata[ERR_W-1:0] : '0;
    assign unused_wdata = ^reg_wdata;

    rpr_mode_ctl #(.SETTLE(SETTLE)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mode    (wr_mode),
        .wr_code    (reg_wdata[1:0]),
        .force_reset(sw_rst),
        .mode_o     (mode),
        .settled_o  (settled),
        .to_reset_o (to_reset)
    );

    rpr_flag_bank #(.W(SVC_W)) u_svc (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({in_done_evt, out_done_evt, in_svc_req, out_svc_req}),
        .clr_i  (svc_clr),
        .flush_i(sw_rst),
        .q_o    (svc_q)
    );

    rpr_flag_bank #(.W(ERR_W)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_evt),
        .clr_i  (err_clr),
        .flush_i(sw_rst || to_reset),
        .q_o    (err_q)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flush = sw_rst;
        if (reg_we && reg_addr == A_ERREN) st_d.err_en = reg_wdata[ERR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MODE: begin
                reg_rdata[1:0] = mode;
                reg_rdata[2]   = settled;
                reg_rdata[4]   = mst_ready;
            end
            A_FLAGS: begin
                reg_rdata[4] = out_not_empty;
                reg_rdata[5] = in_not_empty;
                reg_rdata[6] = out_full;
                reg_rdata[SVC_LSB +: SVC_W] = svc_q;
            end
            A_ERR:   reg_rdata[ERR_W-1:0] = err_q;
            A_ERREN: reg_rdata[ERR_W-1:0] = st_q.err_en;
            default: reg_rdata = '0;
        endcase
    end

    assign core_state = mode;
    assign engine_run = settled && (mode == MODE_RUN);
    assign fifo_flush = st_q.flush;
    assign irq        = (|svc_q) || (|(err_q & st_q.err_en));

    // R5
    swrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!irq && fifo_flush && !engine_run && core_state == 2'd0));
    // R11
    reset_code_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && reg_wdata[1:0] == 2'd0 && settled) |=> (err_q == '0));
endmodule

// File: tb/test_rpr_ctl.sv
module test_rpr_ctl;
    localparam int SETTLE = 6;
    localparam int ERR_W  = 5;

    logic        clk = 0, rst_n = 0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mst_ready = 1, out_not_empty = 0, in_not_empty = 0, out_full = 0;
    logic        out_svc_req = 0, in_svc_req = 0, out_done_evt = 0, in_done_evt = 0;
    logic [ERR_W-1:0] err_evt = '0;
    logic        engine_run, fifo_flush, irq;
    logic [1:0]  core_state;

    int vecs = 0, bad = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          pin_q[$];

    rpr_ctl #(.SETTLE(SETTLE), .ERR_W(ERR_W)) i_rpr_ctl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mst_ready(mst_ready),
        .out_not_empty(out_not_empty), .in_not_empty(in_not_empty), .out_full(out_full),
        .out_svc_req(out_svc_req), .in_svc_req(in_svc_req), .out_done_evt(out_done_evt),
        .in_done_evt(in_done_evt), .err_evt(err_evt), .engine_run(engine_run),
        .core_state(core_state), .fifo_flush(fifo_flush), .irq(irq)
    );

    always #2 clk = ~clk;

    // monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e, obs;
            string t;
            bit p;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            p = pin_q.pop_front();
            obs = p ? {29'b0, fifo_flush, engine_run, irq} : reg_rdata;
            vecs++;
            if (obs !== e) begin
                bad++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", t, obs, e);
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t); pin_q.push_back(1'b0);
        @(negedge clk); #1;
    endtask

    // expected {fifo_flush, engine_run, irq}
    task automatic pins(input logic [2:0] e, input string t);
        exp_q.push_back({29'b0, e}); tag_q.push_back(t); pin_q.push_back(1'b1);
        @(negedge clk); #1;
    endtask

    task automatic wr_ev(input bit we, input logic [2:0] a, input logic [31:0] d,
                         input logic [3:0] svc, input logic [ERR_W-1:0] er);
        @(posedge clk); #1;
        reg_we = we; reg_addr = a; reg_wdata = d;
        {in_done_evt, out_done_evt, in_svc_req, out_svc_req} = svc;
        err_evt = er;
        @(posedge clk); #1;
        reg_we = 0; {in_done_evt, out_done_evt, in_svc_req, out_svc_req} = '0; err_evt = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_ev(1'b1, a, d, 4'b0, '0);
    endtask

    task automatic settle();
        repeat (SETTLE + 1) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        rd(3'd0, 32'h14, "R1 reset mode");
        pins(3'b000, "R6 reset idle");
        rd(3'd2, 32'h0, "R7 reset flags");

        wr(3'd0, 32'h1);
        rd(3'd0, 32'h11, "R2 run written, unsettled");
        pins(3'b000, "R6 no run while settling");
        repeat (4) @(posedge clk); #1;
        rd(3'd0, 32'h11, "R3 last cycle of window");
        @(posedge clk); #1;
        rd(3'd0, 32'h15, "R3 window closed");
        pins(3'b010, "R6 engine runs");

        wr(3'd0, 32'h2);
        rd(3'd0, 32'h15, "R4 code 2 ignored");
        wr(3'd0, 32'h3);
        wr(3'd0, 32'h1);
        rd(3'd0, 32'h13, "R4 write in window ignored");
        settle();
        rd(3'd0, 32'h17, "R4 pause settled");
        pins(3'b000, "R6 pause holds engine");
        mst_ready = 0;
        rd(3'd0, 32'h07, "R1 master ready bit");
        mst_ready = 1;

        out_not_empty = 1; out_full = 1;
        rd(3'd2, 32'h50, "R7 live fifo status");
        out_not_empty = 0; out_full = 0; in_not_empty = 1;
        rd(3'd2, 32'h20, "R7 in not empty");
        in_not_empty = 0;

        wr_ev(1'b0, 3'd2, 32'h0, 4'b0001, '0);
        rd(3'd2, 32'h100, "R8 out service sticky");
        pins(3'b001, "R10 irq from service");
        wr_ev(1'b0, 3'd2, 32'h0, 4'b1000, '0);
        wr(3'd2, 32'h0FF);
        rd(3'd2, 32'h900, "R8 other bits no effect");
        wr(3'd2, 32'h100);
        rd(3'd2, 32'h800, "R8 clear out service");
        wr(3'd2, 32'h800);
        rd(3'd2, 32'h0, "R8 clear in done");
        pins(3'b000, "R10 irq dropped");
        wr_ev(1'b1, 3'd2, 32'h200, 4'b0010, '0);
        rd(3'd2, 32'h200, "R9 set wins over clear");
        wr(3'd2, 32'h200);

        wr_ev(1'b0, 3'd0, 32'h0, 4'b0, 5'b00100);
        rd(3'd3, 32'h4, "R10 error sticky");
        pins(3'b000, "R10 masked error no irq");
        wr(3'd4, 32'h4);
        pins(3'b001, "R10 enabled error irq");
        wr(3'd3, 32'h4);
        rd(3'd3, 32'h0, "R10 error w1c");
        wr_ev(1'b0, 3'd0, 32'h0, 4'b0, 5'b00011);
        rd(3'd3, 32'h3, "R10 two errors");
        wr(3'd0, 32'h0);
        rd(3'd3, 32'h0, "R11 reset code clears errors");
        settle();

        wr(3'd0, 32'h1);
        settle();
        wr_ev(1'b0, 3'd0, 32'h0, 4'b0001, 5'b00100);
        pins(3'b011, "R6 run with irq");
        wr(3'd1, 32'h1);
        pins(3'b100, "R5 flush pulse, quiet");
        rd(3'd0, 32'h10, "R5 forced reset, unsettled");
        rd(3'd2, 32'h0, "R5 flags cleared");
        rd(3'd3, 32'h0, "R5 errors cleared");
        rd(3'd4, 32'h4, "R5 enable kept");
        settle();
        rd(3'd0, 32'h14, "R3 settled after soft reset");
        pins(3'b000, "R5 flush one cycle");

        @(posedge clk); #1;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule